// File: doc/BRIEF.md
# I2C Buffer-Pool Transfer Controller

This block sits between a byte-level I2C master sequencer and a small shared byte pool. The pool holds the outgoing and incoming bytes of multi-byte transfers. Software fills the pool through a CPU port that moves 1 to 4 bytes per access, programs a per-bus pool control word with the transmit count and receive size, and then issues a command. The controller walks the bus's own slice of the pool. It hands each byte to the sequencer through a request/done handshake, and it stores received bytes back into the slice.

A command may combine an address phase, a transmit phase and a receive phase, and they always run in that order. When a START is requested in transmit-buffer mode, the first byte of the slice is the address byte. A receive writes the number of bytes it collected into the upper field of the pool control word. When the pool-enable check is active and the pool is disabled, any command that asks for buffer or DMA service is refused.

Top module: `i2c_pool_xfer`

## Requirements
- R1: After reset, busy, seq_req, xfer_done, xfer_nak, cmd_reject and both pending flags are 0, every pool control word reads 0 and every pool byte reads 0.
- R2: A control write changes only bits 23:0 of the selected bus's word, and bits 31:24 keep their value. The transmit count is bits 15:8 plus one and the receive size is bits 23:16 plus one.
- R3: A command with START and transmit-buffer mode first issues one operation with seq_op = 0 (address) that carries pool byte 0 of the slice. Data then starts at index 1, and no data byte is sent when the transmit count is 1.
- R4: A transmit issues operations with seq_op = 1 that carry slice bytes from the start index up to count minus one, in order. A NAK stops it at once and sets xfer_nak. When the phase ends, txbuf_pending is cleared.
- R5: A receive issues size operations with seq_op = 2 and stores byte k at slice index k. It writes the size modulo 256 into bits 31:24 and clears rxbuf_pending.
- R6: With CHECK_POOL_EN set and pool_en low, a command that has txbuf, rxbuf or dma set pulses cmd_reject on the next cycle, and starts no operation. Commands without these bits are still accepted.
- R7: A CPU access moves cpu_size+1 bytes (cpu_size 0..3). Byte i sits at bits 8i+7:8i and maps to pool address (cpu_addr+i) modulo the pool size. Read data appears the cycle after the request, with unused upper bytes read as 0.
- R8: While seq_req is high and seq_done is low, seq_req, seq_op and seq_wbyte hold steady into the next cycle.
- R9: The slice of bus b begins at pool address b*STRIDE, and indices past the slice wrap modulo the pool size.
- R10: When a received byte and a CPU write target the same pool address in the same cycle, the received byte is stored.
- R11: The phases run address, transmit, receive. A NAK on the address ends the command with no further operation. Every accepted command ends with a single-cycle xfer_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU pool access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Bytes in access minus one |
| cpu_addr | input | POOL_AW | First pool byte address |
| cpu_wdata | input | 32 | Write data, byte i in lane i |
| cpu_rdata | output | 32 | Read data, valid the cycle after a read |
| ctl_we | input | 1 | Pool control write strobe |
| ctl_bus | input | BUS_W | Bus whose control word is written or read |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control word of ctl_bus |
| pool_en | input | 1 | Global pool enable |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_bus | input | BUS_W | Bus the command runs on |
| cmd_start | input | 1 | Address phase requested |
| cmd_tx | input | 1 | Transmit phase requested |
| cmd_rx | input | 1 | Receive phase requested |
| cmd_txbuf | input | 1 | Transmit from pool |
| cmd_rxbuf | input | 1 | Receive into pool |
| cmd_dma | input | 1 | Any DMA enable bit of the command |
| busy | output | 1 | Command in progress |
| xfer_done | output | 1 | One-cycle end-of-command pulse |
| xfer_nak | output | 1 | Last command ended on a NAK |
| cmd_reject | output | 1 | One-cycle refusal pulse |
| txbuf_pending | output | 1 | Transmit-buffer enable still set |
| rxbuf_pending | output | 1 | Receive-buffer enable still set |
| seq_req | output | 1 | Operation request to the sequencer |
| seq_op | output | 2 | 0 address, 1 transmit, 2 receive |
| seq_wbyte | output | 8 | Byte to send |
| seq_done | input | 1 | Sequencer completed the operation |
| seq_nak | input | 1 | NAK for an address or transmit operation |
| seq_rbyte | input | 8 | Received byte, with seq_done |

## Verification
An index that drifts shows on seq_wbyte at the very next request, or shows in the pool as a received byte at the wrong address, which a CPU read exposes one cycle after it is issued. A wrong count or size produces one operation too many or too few before xfer_done. It also leaves a wrong value in bits 31:24 of the control word on the cycle after the last receive. A phase-ordering or NAK-handling fault changes the sequence of seq_op codes, and the pending flags and xfer_nak read back wrong when xfer_done is seen.

// File: rtl/pool_xfer_pkg.sv
// Shared types for the buffer-pool transfer controller.
// Assumes: sequencer operation codes are fixed by the top-level contract.
package pool_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TX,
        ST_RX,
        ST_FIN
    } xfer_state_e;

    localparam logic [1:0] OP_ADDR = 2'd0;
    localparam logic [1:0] OP_TX   = 2'd1;
    localparam logic [1:0] OP_RX   = 2'd2;

endpackage

// File: rtl/pool_byte_ram.sv
// Byte pool with a CPU port (1..4 bytes little-endian, registered read) and
// an engine port (one byte, combinational read, one byte write).
// Assumes: on an address clash in one cycle the engine write has priority.
module pool_byte_ram #(
    parameter int POOL_BYTES = 64,
    localparam int AW = $clog2(POOL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_size,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata
);

    logic [7:0] mem [POOL_BYTES];

    // Engine read is combinational so a request carries its byte at once.
    assign eng_rdata = mem[eng_raddr];

    // Storage update: CPU lanes first, engine last so it wins a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < POOL_BYTES; a++) mem[a] <= '0;
        end else begin
            if (cpu_req && cpu_we) begin
                for (int i = 0; i < 4; i++) begin
                    if (2'(i) <= cpu_size)
                        mem[AW'(cpu_addr + AW'(i))] <= cpu_wdata[8*i +: 8];
                end
            end
            if (eng_we) mem[eng_waddr] <= eng_wdata;
        end
    end

    // CPU read data register, little-endian packing, unused lanes zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_req && !cpu_we) begin
            for (int i = 0; i < 4; i++) begin
                cpu_rdata[8*i +: 8] <= (2'(i) <= cpu_size) ? mem[AW'(cpu_addr + AW'(i))] : 8'h00;
            end
        end
    end

    // R10: a receive write lands even if the CPU wrote the same byte.
    assert_engine_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> mem[$past(eng_waddr)] == $past(eng_wdata));

endmodule

// File: rtl/pool_ctl_regs.sv
// Per-bus pool control words. Software owns bits 23:0; bits 31:24 hold the
// received byte count and are written only by the engine.
// Assumes: one software and one hardware update may arrive in one cycle.
module pool_ctl_regs #(
    parameter int NBUS = 4,
    localparam int BUS_W = $clog2(NBUS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [BUS_W-1:0] sw_bus,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             hw_we,
    input  logic [BUS_W-1:0] hw_bus,
    input  logic [7:0]       hw_cnt,
    input  logic [BUS_W-1:0] sel_bus,
    output logic [7:0]       sel_tx_m1,
    output logic [7:0]       sel_rx_m1
);

    logic [23:0] sw_field [NBUS];
    logic [7:0]  rx_cnt   [NBUS];

    // Field updates: software low part, hardware receive count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBUS; b++) begin
                sw_field[b] <= '0;
                rx_cnt[b]   <= '0;
            end
        end else begin
            for (int b = 0; b < NBUS; b++) begin
                if (sw_we && sw_bus == BUS_W'(b)) sw_field[b] <= sw_wdata[23:0];
                if (hw_we && hw_bus == BUS_W'(b)) rx_cnt[b]   <= hw_cnt;
            end
        end
    end

    // Read mux and engine-side field extraction.
    always_comb begin
        sw_rdata  = {rx_cnt[sw_bus], sw_field[sw_bus]};
        sel_tx_m1 = sw_field[sel_bus][15:8];
        sel_rx_m1 = sw_field[sel_bus][23:16];
    end

    // R2: a software write never disturbs the receive count.
    assert_count_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_we) |=> rx_cnt[$past(sw_bus)] == $past(rx_cnt[sw_bus]));

endmodule

// File: rtl/pool_xfer_engine.sv
// Command sequencer: address, transmit and receive phases over one bus slice.
// Assumes: the sequencer holds seq_done for one cycle per operation, and
// control words are stable while a command is accepted.
module pool_xfer_engine
    import pool_xfer_pkg::*;
#(
    parameter int NBUS          = 4,
    parameter int STRIDE        = 16,
    parameter bit CHECK_POOL_EN = 1'b1,
    localparam int POOL_BYTES = NBUS * STRIDE,
    localparam int AW         = $clog2(POOL_BYTES),
    localparam int BUS_W      = $clog2(NBUS),
    localparam int IDX_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pool_en,
    input  logic             cmd_valid,
    input  logic [BUS_W-1:0] cmd_bus,
    input  logic             cmd_start,
    input  logic             cmd_tx,
    input  logic             cmd_rx,
    input  logic             cmd_txbuf,
    input  logic             cmd_rxbuf,
    input  logic             cmd_dma,
    output logic [BUS_W-1:0] sel_bus,
    input  logic [7:0]       tx_m1,
    input  logic [7:0]       rx_m1,
    output logic [AW-1:0]    pool_addr,
    input  logic [7:0]       pool_rdata,
    output logic             pool_we,
    output logic [7:0]       pool_wdata,
    output logic             cnt_we,
    output logic [7:0]       cnt_val,
    output logic             busy,
    output logic             done,
    output logic             nak,
    output logic             reject,
    output logic             txbuf_pend,
    output logic             rxbuf_pend,
    output logic             seq_req,
    output logic [1:0]       seq_op,
    output logic [7:0]       seq_wbyte,
    input  logic             seq_done,
    input  logic             seq_nak,
    input  logic [7:0]       seq_rbyte
);

    xfer_state_e      state;
    logic [BUS_W-1:0] bus_q;
    logic             tx_q, rx_q;
    logic [IDX_W-1:0] idx, idx_nx, txcnt, rxsize;
    logic             refuse, rx_last;

    // Refusal and index helpers.
    always_comb begin
        refuse  = CHECK_POOL_EN && !pool_en && (cmd_txbuf || cmd_rxbuf || cmd_dma);
        idx_nx  = IDX_W'(idx + 1'b1);
        rx_last = (state == ST_RX) && seq_done && (idx_nx == rxsize);
        sel_bus = (state == ST_IDLE) ? cmd_bus : bus_q;
    end

    // Pool addressing: slice base plus index, wrapped to the pool.
    always_comb begin
        pool_addr  = AW'(int'(bus_q) * STRIDE + int'(idx));
        pool_we    = (state == ST_RX) && seq_done;
        pool_wdata = seq_rbyte;
        cnt_we     = rx_last;
        cnt_val    = rxsize[7:0];
    end

    // Sequencer request decode from the phase register.
    always_comb begin
        seq_req   = (state == ST_ADDR) || (state == ST_TX) || (state == ST_RX);
        seq_wbyte = pool_rdata;
        unique case (state)
            ST_ADDR: seq_op = OP_ADDR;
            ST_RX:   seq_op = OP_RX;
            default: seq_op = OP_TX;
        endcase
        busy = (state != ST_IDLE);
        done = (state == ST_FIN);
    end

    // Phase sequencing, index stepping and pending-flag bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bus_q      <= '0;
            tx_q       <= 1'b0;
            rx_q       <= 1'b0;
            txbuf_pend <= 1'b0;
            rxbuf_pend <= 1'b0;
            idx        <= '0;
            txcnt      <= '0;
            rxsize     <= '0;
            nak        <= 1'b0;
            reject     <= 1'b0;
        end else begin
            reject <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (refuse) begin
                            reject <= 1'b1;
                        end else begin
                            bus_q      <= cmd_bus;
                            tx_q       <= cmd_tx;
                            rx_q       <= cmd_rx;
                            txbuf_pend <= cmd_txbuf;
                            rxbuf_pend <= cmd_rxbuf;
                            nak        <= 1'b0;
                            idx        <= '0;
                            txcnt      <= IDX_W'(tx_m1) + 1'b1;
                            rxsize     <= IDX_W'(rx_m1) + 1'b1;
                            if (cmd_start && cmd_txbuf)      state <= ST_ADDR;
                            else if (cmd_tx && cmd_txbuf)    state <= ST_TX;
                            else if (cmd_rx && cmd_rxbuf)    state <= ST_RX;
                            else                             state <= ST_FIN;
                        end
                    end
                end
                ST_ADDR: begin
                    if (seq_done) begin
                        if (seq_nak) begin
                            nak        <= 1'b1;
                            txbuf_pend <= 1'b0;
                            state      <= ST_FIN;
                        end else if (tx_q && txcnt > IDX_W'(1)) begin
                            idx   <= IDX_W'(1);
                            state <= ST_TX;
                        end else begin
                            txbuf_pend <= 1'b0;
                            idx        <= '0;
                            state      <= (rx_q && rxbuf_pend) ? ST_RX : ST_FIN;
                        end
                    end
                end
                ST_TX: begin
                    if (seq_done) begin
                        if (seq_nak) begin
                            nak        <= 1'b1;
                            txbuf_pend <= 1'b0;
                            state      <= ST_FIN;
                        end else if (idx_nx == txcnt) begin
                            txbuf_pend <= 1'b0;
                            idx        <= '0;
                            state      <= (rx_q && rxbuf_pend) ? ST_RX : ST_FIN;
                        end else begin
                            idx <= idx_nx;
                        end
                    end
                end
                ST_RX: begin
                    if (seq_done) begin
                        if (rx_last) begin
                            rxbuf_pend <= 1'b0;
                            idx        <= '0;
                            state      <= ST_FIN;
                        end else begin
                            idx <= idx_nx;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: the transmit index never reaches the count.
    assert_tx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> (idx < txcnt));

    // R5: the receive index never reaches the size.
    assert_rx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX) |-> (idx < rxsize));

    // R3: an accepted START in transmit-buffer mode opens with an address request.
    assert_addr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && !refuse && cmd_start && cmd_txbuf)
        |=> (seq_req && seq_op == OP_ADDR));

endmodule

// File: rtl/i2c_pool_xfer.sv
// Top of the buffer-pool transfer controller: pool RAM, control words and
// command engine. Assumes a single clock and synchronous active-low reset.
module i2c_pool_xfer #(
    parameter int NBUS          = 4,
    parameter int STRIDE        = 16,
    parameter bit CHECK_POOL_EN = 1'b1,
    localparam int POOL_BYTES = NBUS * STRIDE,
    localparam int POOL_AW    = $clog2(POOL_BYTES),
    localparam int BUS_W      = $clog2(NBUS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_size,
    input  logic [POOL_AW-1:0] cpu_addr,
    input  logic [31:0]        cpu_wdata,
    output logic [31:0]        cpu_rdata,
    input  logic               ctl_we,
    input  logic [BUS_W-1:0]   ctl_bus,
    input  logic [31:0]        ctl_wdata,
    output logic [31:0]        ctl_rdata,
    input  logic               pool_en,
    input  logic               cmd_valid,
    input  logic [BUS_W-1:0]   cmd_bus,
    input  logic               cmd_start,
    input  logic               cmd_tx,
    input  logic               cmd_rx,
    input  logic               cmd_txbuf,
    input  logic               cmd_rxbuf,
    input  logic               cmd_dma,
    output logic               busy,
    output logic               xfer_done,
    output logic               xfer_nak,
    output logic               cmd_reject,
    output logic               txbuf_pending,
    output logic               rxbuf_pending,
    output logic               seq_req,
    output logic [1:0]         seq_op,
    output logic [7:0]         seq_wbyte,
    input  logic               seq_done,
    input  logic               seq_nak,
    input  logic [7:0]         seq_rbyte
);

    logic [BUS_W-1:0]   sel_bus;
    logic [7:0]         tx_m1, rx_m1, pool_rdata, pool_wdata, cnt_val;
    logic [POOL_AW-1:0] pool_addr;
    logic               pool_we, cnt_we;

    pool_byte_ram #(.POOL_BYTES(POOL_BYTES)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_raddr(pool_addr), .eng_rdata(pool_rdata),
        .eng_we(pool_we), .eng_waddr(pool_addr), .eng_wdata(pool_wdata)
    );

    pool_ctl_regs #(.NBUS(NBUS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_we(ctl_we), .sw_bus(ctl_bus), .sw_wdata(ctl_wdata), .sw_rdata(ctl_rdata),
        .hw_we(cnt_we), .hw_bus(sel_bus), .hw_cnt(cnt_val),
        .sel_bus(sel_bus), .sel_tx_m1(tx_m1), .sel_rx_m1(rx_m1)
    );

    pool_xfer_engine #(.NBUS(NBUS), .STRIDE(STRIDE), .CHECK_POOL_EN(CHECK_POOL_EN)) u_eng (
        .clk(clk), .rst_n(rst_n), .pool_en(pool_en),
        .cmd_valid(cmd_valid), .cmd_bus(cmd_bus), .cmd_start(cmd_start),
        .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_txbuf(cmd_txbuf),
        .cmd_rxbuf(cmd_rxbuf), .cmd_dma(cmd_dma),
        .sel_bus(sel_bus), .tx_m1(tx_m1), .rx_m1(rx_m1),
        .pool_addr(pool_addr), .pool_rdata(pool_rdata),
        .pool_we(pool_we), .pool_wdata(pool_wdata),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .busy(busy), .done(xfer_done), .nak(xfer_nak), .reject(cmd_reject),
        .txbuf_pend(txbuf_pending), .rxbuf_pend(rxbuf_pending),
        .seq_req(seq_req), .seq_op(seq_op), .seq_wbyte(seq_wbyte),
        .seq_done(seq_done), .seq_nak(seq_nak), .seq_rbyte(seq_rbyte)
    );

    // R8: a pending request holds its operation and byte until done.
    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_op) && $stable(seq_wbyte)));

    // R11: the completion pulse lasts exactly one cycle.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R6: a refusal never coincides with a running command.
    assert_reject_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !busy);

endmodule

// File: tb/i2c_pool_xfer_tb_top.sv
// Self-checking bench: sweeps CPU access shapes, transmit counts, buses and
// receive sizes against an arithmetic model of the pool.
module i2c_pool_xfer_tb_top;

    localparam int NB = 4;
    localparam int ST = 16;
    localparam int PB = NB * ST;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [1:0]  cpu_size = 0;
    logic [5:0]  cpu_addr = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        ctl_we = 0;
    logic [1:0]  ctl_bus = 0;
    logic [31:0] ctl_wdata = 0, ctl_rdata;
    logic        pool_en = 1;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_bus = 0;
    logic        cmd_start = 0, cmd_tx = 0, cmd_rx = 0, cmd_txbuf = 0, cmd_rxbuf = 0, cmd_dma = 0;
    logic        busy, xfer_done, xfer_nak, cmd_reject, txbuf_pending, rxbuf_pending;
    logic        seq_req;
    logic [1:0]  seq_op;
    logic [7:0]  seq_wbyte;
    logic        seq_done = 0, seq_nak = 0;
    logic [7:0]  seq_rbyte = 0;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mdl [PB];
    logic [1:0] log_op [300];
    logic [7:0] log_b  [300];
    int nlog = 0, rxk = 0, nak_at = -1, col_k = -1, hs_err = 0;
    logic [5:0] col_addr = 0;
    logic rej_seen;

    always #5 clk = ~clk;

    i2c_pool_xfer #(.NBUS(NB), .STRIDE(ST), .CHECK_POOL_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ctl_we(ctl_we), .ctl_bus(ctl_bus), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .pool_en(pool_en),
        .cmd_valid(cmd_valid), .cmd_bus(cmd_bus), .cmd_start(cmd_start), .cmd_tx(cmd_tx),
        .cmd_rx(cmd_rx), .cmd_txbuf(cmd_txbuf), .cmd_rxbuf(cmd_rxbuf), .cmd_dma(cmd_dma),
        .busy(busy), .xfer_done(xfer_done), .xfer_nak(xfer_nak), .cmd_reject(cmd_reject),
        .txbuf_pending(txbuf_pending), .rxbuf_pending(rxbuf_pending),
        .seq_req(seq_req), .seq_op(seq_op), .seq_wbyte(seq_wbyte),
        .seq_done(seq_done), .seq_nak(seq_nak), .seq_rbyte(seq_rbyte)
    );

    function automatic logic [7:0] rbyte(input int k);
        return 8'(8'h5A + k * 13);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_size = sz; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        for (int i = 0; i <= int'(sz); i++) mdl[6'(int'(a) + i)] = d[8*i +: 8];
    endtask

    task automatic cpu_rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a; cpu_size = sz;
        @(negedge clk);
        cpu_req = 0;
        d = cpu_rdata;
    endtask

    task automatic ctl_wr(input logic [1:0] b, input logic [31:0] d);
        @(negedge clk);
        ctl_we = 1; ctl_bus = b; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic ctl_rd(input logic [1:0] b, output logic [31:0] d);
        @(negedge clk);
        ctl_bus = b;
        @(negedge clk);
        d = ctl_rdata;
    endtask

    task automatic verify_pool(input string req);
        logic [31:0] d;
        for (int a = 0; a < PB; a += 4) begin
            cpu_rd(6'(a), 2'd3, d);
            check(req, d, {mdl[a+3], mdl[a+2], mdl[a+1], mdl[a]});
        end
    endtask

    task automatic run_cmd(input logic [1:0] b, input logic s, input logic t, input logic r,
                           input logic tb, input logic rb, input logic dm, output logic got);
        nlog = 0; rxk = 0; hs_err = 0; got = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_bus = b; cmd_start = s; cmd_tx = t; cmd_rx = r;
        cmd_txbuf = tb; cmd_rxbuf = rb; cmd_dma = dm;
        @(negedge clk);
        cmd_valid = 0;
        rej_seen = cmd_reject;
        for (int w = 0; w < 4000; w++) begin
            if (xfer_done === 1'b1) begin got = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Sequencer model: variable latency, optional NAK, collision injection.
    initial begin
        logic [1:0] op0;
        logic [7:0] b0;
        forever begin
            @(negedge clk);
            if (seq_req === 1'b1) begin
                op0 = seq_op; b0 = seq_wbyte;
                repeat (nlog % 3) @(negedge clk);
                if (seq_op !== op0 || seq_wbyte !== b0 || seq_req !== 1'b1) hs_err++;
                log_op[nlog] = op0; log_b[nlog] = b0;
                seq_nak   = (nlog == nak_at);
                seq_rbyte = rbyte(rxk);
                if (op0 == 2'd2 && rxk == col_k) begin
                    cpu_req = 1; cpu_we = 1; cpu_addr = col_addr; cpu_size = 0; cpu_wdata = 32'hFF;
                end
                if (op0 == 2'd2) rxk++;
                nlog++;
                seq_done = 1;
                @(negedge clk);
                seq_done = 0; seq_nak = 0; cpu_req = 0; cpu_we = 0;
            end
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] d, e;
        logic got;
        for (int a = 0; a < PB; a++) mdl[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state at the ports.
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 seq_req", {31'b0, seq_req}, 0);
        check("R1 flags", {26'b0, xfer_done, xfer_nak, cmd_reject, txbuf_pending, rxbuf_pending, 1'b0}, 0);
        for (int b = 0; b < NB; b++) begin
            ctl_rd(2'(b), d);
            check("R1 ctl", d, 0);
        end
        verify_pool("R1 pool");

        // R7: writes of every size at every offset, including wrap at the top.
        for (int a = 0; a < PB; a++) begin
            cpu_wr(6'(a), 2'(a % 4), 32'(a * 32'h01030507 + 32'h10203040));
        end
        cpu_wr(6'd63, 2'd3, 32'hC3B2A190);
        for (int a = 0; a < PB; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                cpu_rd(6'(a), 2'(sz), d);
                e = 0;
                for (int i = 0; i <= sz; i++) e[8*i +: 8] = mdl[(a + i) % PB];
                check("R7 cpu read", d, e);
            end
        end

        // Known pool pattern for the transfer tests.
        for (int a = 0; a < PB; a += 4)
            cpu_wr(6'(a), 2'd3, {8'(a*3+20), 8'(a*3+17), 8'(a*3+14), 8'(a*3+11)});

        // R2: only bits 23:0 are writable.
        ctl_wr(2'd2, 32'hFFFFFFFF);
        ctl_rd(2'd2, d);
        check("R2 low only", d, 32'h00FFFFFF);

        // R3 R4 R9 R11: transmit sweep over bus, count and START.
        for (int b = 0; b < NB; b++) begin
            for (int c = 1; c <= 6; c++) begin
                for (int s = 0; s < 2; s++) begin
                    ctl_wr(2'(b), 32'((c - 1) << 8));
                    run_cmd(2'(b), 1'(s), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, got);
                    check("R11 done seen", {31'b0, got}, 1);
                    check("R4 op count", nlog, c);
                    for (int j = 0; j < c; j++) begin
                        check("R3 R4 op", {30'b0, log_op[j]}, (s == 1 && j == 0) ? 0 : 1);
                        check("R4 R9 byte", {24'b0, log_b[j]}, {24'b0, mdl[b * ST + j]});
                    end
                    check("R4 txbuf cleared", {31'b0, txbuf_pending}, 0);
                    check("R4 no nak", {31'b0, xfer_nak}, 0);
                    check("R8 held", hs_err, 0);
                end
            end
        end

        // R4: NAK on the third data byte stops the transmit.
        ctl_wr(2'd1, 32'h00000500);
        nak_at = 2;
        run_cmd(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, got);
        nak_at = -1;
        check("R4 nak stop count", nlog, 3);
        check("R4 nak flag", {31'b0, xfer_nak}, 1);
        check("R4 nak txbuf cleared", {31'b0, txbuf_pending}, 0);

        // R11: NAK on the address ends the command before transmit and receive.
        ctl_wr(2'd2, 32'h00030300);
        nak_at = 0;
        run_cmd(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, got);
        nak_at = -1;
        check("R11 addr nak count", nlog, 1);
        check("R11 addr nak flag", {31'b0, xfer_nak}, 1);

        // R5 R11: address, two data bytes, four received bytes on bus 3.
        ctl_wr(2'd3, 32'h00030200);
        run_cmd(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, got);
        check("R11 full count", nlog, 7);
        for (int j = 0; j < 7; j++) begin
            check("R11 phase order", {30'b0, log_op[j]}, (j == 0) ? 0 : (j < 3 ? 1 : 2));
            if (j < 3) check("R3 full tx byte", {24'b0, log_b[j]}, {24'b0, mdl[48 + j]});
        end
        for (int k = 0; k < 4; k++) mdl[48 + k] = rbyte(k);
        ctl_rd(2'd3, d);
        check("R5 rx count", d, 32'h04030200);
        check("R5 rxbuf cleared", {31'b0, rxbuf_pending}, 0);
        verify_pool("R5 pool");

        // R2: a later write keeps the hardware count.
        ctl_wr(2'd3, 32'hAB000001);
        ctl_rd(2'd3, d);
        check("R2 count kept", d, 32'h04000001);

        // R5: receive sizes 1 and 16 on bus 2.
        for (int z = 0; z < 2; z++) begin
            int sz;
            sz = (z == 0) ? 1 : 16;
            ctl_wr(2'd2, 32'((sz - 1) << 16));
            run_cmd(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, got);
            check("R5 rx ops", nlog, sz);
            for (int k = 0; k < sz; k++) mdl[32 + k] = rbyte(k);
            ctl_rd(2'd2, d);
            check("R5 rx size count", {24'b0, d[31:24]}, sz);
            verify_pool("R5 pool sizes");
        end

        // R10: CPU write to the same byte as a received byte in one cycle.
        ctl_wr(2'd1, 32'h00030000);
        col_k = 2; col_addr = 6'd18;
        run_cmd(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, got);
        col_k = -1;
        for (int k = 0; k < 4; k++) mdl[16 + k] = rbyte(k);
        cpu_rd(6'd18, 2'd0, d);
        check("R10 engine wins", d, {24'b0, rbyte(2)});
        verify_pool("R10 pool");

        // R5 R9: 256-byte receive wraps the pool and stores count 0.
        ctl_wr(2'd0, 32'h00FF0000);
        run_cmd(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, got);
        check("R5 256 ops", nlog, 256);
        for (int k = 0; k < 256; k++) mdl[k % PB] = rbyte(k);
        ctl_rd(2'd0, d);
        check("R5 256 count", d, 32'h00FF0000);
        verify_pool("R9 wrap pool");

        // R6: refusal with pool disabled.
        pool_en = 0;
        run_cmd(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, got);
        check("R6 reject pulse", {31'b0, rej_seen}, 1);
        check("R6 no ops", nlog, 0);
        check("R6 no done", {31'b0, got}, 0);
        check("R6 pulse ends", {31'b0, cmd_reject}, 0);
        run_cmd(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, got);
        check("R6 dma reject", {31'b0, rej_seen}, 1);
        run_cmd(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, got);
        check("R6 plain accepted", {31'b0, rej_seen}, 0);
        check("R6 plain done", {31'b0, got}, 1);
        check("R6 plain no ops", nlog, 0);
        pool_en = 1;
        verify_pool("R6 pool untouched");

        finish_up();
    end

endmodule